// File: doc/BRIEF.md
# Physical Address Routing Decoder

This block takes one processor bus request at a time, carrying a physical address in 8-byte units (byte address bits 35:3, 64 GB of reachable space), and decides which target serves it: main DRAM, the graphics aperture, the PCI/MMIO hole below 4 GB, the boot flash, the legacy 640 KB–1 MB hole, or an error/abort target. For DRAM-bound requests it also produces the DRAM-local address.

Installed DRAM that would sit under the device hole below 4 GB can be reached again through a reclaim window above the top of memory. A request that hits this window is sent to DRAM with its address moved down onto the hidden range. The boundaries of low usable memory, top of memory and the reclaim window are held in configuration registers in 64 MB granules, written through a small write port. The result is registered and held under a valid/ready handshake until the consumer takes it.

Top module: `addr_route_dec`

## Requirements
- R1: After reset, rsp_valid is 0 and req_ready is 1. The configuration resets to low-memory top 48 (3 GB), top of memory 64 (4 GB), reclaim base 64, reclaim limit 79 (64 MB granules) and reclaim disabled.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. Its result shows on rsp_valid/rsp_tgt/rsp_addr right after that edge. req_ready is 1 exactly when rsp_valid is 0 or rsp_ready is 1.
- R3: While rsp_valid is 1 and rsp_ready is 0, rsp_tgt and rsp_addr hold their values, and no new request is accepted.
- R4: rsp_tgt is one-hot whenever rsp_valid is 1. Bit 0 is DRAM, bit 1 is legacy, bit 2 is MMIO, bit 3 is graphics, bit 4 is flash and bit 5 is error.
- R5: Byte addresses 0xFF00_0000 to 0xFFFF_FFFF go to flash. This window has the highest priority.
- R6: Byte addresses 0xE000_0000 to 0xEFFF_FFFF go to graphics. Only flash outranks this window.
- R7: Byte addresses from the low-memory top up to 4 GB that flash and graphics do not take go to MMIO.
- R8: Byte addresses 0xA_0000 to 0xF_FFFF go to legacy and never to DRAM.
- R9: Reclaim applies when it is enabled and base ≤ limit. A hit in [base·64 MB, (limit+1)·64 MB) that no higher-priority window takes goes to DRAM, with rsp_addr = address − base·64 MB + low-memory top·64 MB.
- R10: When reclaim is disabled, or base > limit, the reclaim window has no effect, and addresses in it decode as if it did not exist.
- R11: Any other address below top of memory goes to DRAM, with rsp_addr equal to the request address.
- R12: An address that matches nothing and lies at or above top of memory goes to error. For all targets other than a reclaim hit, rsp_addr equals the request address.
- R13: A write with cfg_we = 1 sets the field chosen by cfg_idx. Index 0 is the low-memory top, 1 the reclaim base, 2 the reclaim limit, 3 the top of memory and 4 the reclaim enable (cfg_wdata bit 0). The new value applies to requests accepted from the next rising edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Selects the configuration field |
| cfg_wdata | input | 10 | Value to write (64 MB granules, or enable in bit 0) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Decoder can take a request |
| req_addr | input | 33 | Physical byte address bits 35:3 |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_tgt | output | 6 | One-hot target select |
| rsp_addr | output | 33 | Translated address in 8-byte units |

## Verification
A decode result is due one clock after the rising edge that accepts the request. A configuration write affects requests accepted from the following edge on. The bench drives on the falling edge and checks each result on the next falling edge, which comes right after the one accepting edge. It applies the configuration a full cycle before issuing the request. In the stall case the held result is sampled on every falling edge while the consumer refuses it. The waiting request is then expected on the falling edge after the release.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;
    localparam int AW         = 33;      // byte address bits 35:3
    localparam int BW         = 10;      // 64 MB granule boundary width
    localparam int UNIT_SHIFT = 23;      // 64 MB in 8-byte units = 2^23
    localparam int NT         = 6;

    localparam int T_DRAM   = 0;
    localparam int T_LEGACY = 1;
    localparam int T_MMIO   = 2;
    localparam int T_GFX    = 3;
    localparam int T_FLASH  = 4;
    localparam int T_ERR    = 5;

    typedef struct packed {
        logic [BW-1:0] low_top;
        logic [BW-1:0] rc_base;
        logic [BW-1:0] rc_limit;
        logic [BW-1:0] mem_top;
        logic          rc_en;
    } route_cfg_t;

    typedef struct packed {
        logic          valid;
        logic [NT-1:0] tgt;
        logic [AW-1:0] addr;
    } route_rsp_t;
endpackage

// File: rtl/addr_route_cfg.sv
module addr_route_cfg
    import addr_route_pkg::*;
#(
    parameter logic [BW-1:0] RST_LOW_TOP  = 10'd48,
    parameter logic [BW-1:0] RST_MEM_TOP  = 10'd64,
    parameter logic [BW-1:0] RST_RC_BASE  = 10'd64,
    parameter logic [BW-1:0] RST_RC_LIMIT = 10'd79
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    idx,
    input  logic [BW-1:0] wdata,
    output route_cfg_t    cfg
);
    route_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (idx)
                3'd0:    cfg_d.low_top  = wdata;
                3'd1:    cfg_d.rc_base  = wdata;
                3'd2:    cfg_d.rc_limit = wdata;
                3'd3:    cfg_d.mem_top  = wdata;
                3'd4:    cfg_d.rc_en    = wdata[0];
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.low_top  <= RST_LOW_TOP;
            cfg_q.rc_base  <= RST_RC_BASE;
            cfg_q.rc_limit <= RST_RC_LIMIT;
            cfg_q.mem_top  <= RST_MEM_TOP;
            cfg_q.rc_en    <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R13: a write lands on the next edge
    p_cfg_low_top_r13: assert property (@(posedge clk) disable iff (!rst_n)
        we && idx == 3'd0 |=> cfg_q.low_top == $past(wdata));
    p_cfg_mem_top_r13: assert property (@(posedge clk) disable iff (!rst_n)
        we && idx == 3'd3 |=> cfg_q.mem_top == $past(wdata));
    p_cfg_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));
endmodule

// File: rtl/addr_route_match.sv
module addr_route_match
    import addr_route_pkg::*;
#(
    parameter int unsigned GFX_BASE   = 56,  // 64 MB granules
    parameter int unsigned GFX_SIZE   = 4,
    parameter int unsigned FLASH_LOG2 = 24   // flash window bytes, log2
) (
    input  logic [AW-1:0] addr,
    input  route_cfg_t    cfg,
    output logic [NT-1:0] tgt,
    output logic [AW-1:0] xaddr
);
    localparam int EW = AW + 1;
    localparam int NH = 6;
    localparam logic [EW-1:0] FOUR_G   = EW'(1) << (32 - 3);
    localparam logic [EW-1:0] FLASH_LO = FOUR_G - (EW'(1) << (FLASH_LOG2 - 3));
    localparam logic [EW-1:0] GFX_LO   = EW'(GFX_BASE) << UNIT_SHIFT;
    localparam logic [EW-1:0] GFX_HI   = EW'(GFX_BASE + GFX_SIZE) << UNIT_SHIFT;
    localparam logic [EW-1:0] LEG_LO   = EW'(32'h000A_0000 >> 3);
    localparam logic [EW-1:0] LEG_HI   = EW'(32'h0010_0000 >> 3);
    // hit index order is the decode priority
    localparam int HIT_TGT [NH] = '{T_FLASH, T_GFX, T_MMIO, T_LEGACY, T_DRAM, T_DRAM};
    localparam int H_RECLAIM = 4;

    logic [EW-1:0] a_e, low_e, top_e, rb_e, re_e;
    logic [NH-1:0] hit;
    logic          found;
    logic          rc_win;

    assign a_e   = {1'b0, addr};
    assign low_e = EW'(cfg.low_top) << UNIT_SHIFT;
    assign top_e = EW'(cfg.mem_top) << UNIT_SHIFT;
    assign rb_e  = EW'(cfg.rc_base) << UNIT_SHIFT;
    assign re_e  = (EW'(cfg.rc_limit) + EW'(1)) << UNIT_SHIFT;

    always_comb begin
        hit[0] = (a_e >= FLASH_LO) && (a_e < FOUR_G);
        hit[1] = (a_e >= GFX_LO)   && (a_e < GFX_HI);
        hit[2] = (a_e >= low_e)    && (a_e < FOUR_G);
        hit[3] = (a_e >= LEG_LO)   && (a_e < LEG_HI);
        hit[4] = cfg.rc_en && (cfg.rc_base <= cfg.rc_limit)
                 && (a_e >= rb_e) && (a_e < re_e);
        hit[5] = (a_e < top_e);
    end

    always_comb begin
        tgt    = '0;
        found  = 1'b0;
        rc_win = 1'b0;
        for (int i = 0; i < NH; i++) begin
            if (hit[i] && !found) begin
                tgt[HIT_TGT[i]] = 1'b1;
                found           = 1'b1;
                rc_win          = (i == H_RECLAIM);
            end
        end
        if (!found) tgt[T_ERR] = 1'b1;
    end

    assign xaddr = rc_win ? AW'(a_e - rb_e + low_e) : addr;
endmodule

// File: rtl/addr_route_dec.sv
module addr_route_dec
    import addr_route_pkg::*;
#(
    parameter int unsigned GFX_BASE   = 56,
    parameter int unsigned GFX_SIZE   = 4,
    parameter int unsigned FLASH_LOG2 = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_idx,
    input  logic [9:0]    cfg_wdata,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [32:0]   req_addr,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [5:0]    rsp_tgt,
    output logic [32:0]   rsp_addr
);
    localparam logic [AW-1:0] FL_LO = AW'(33'h2000_0000 - (33'd1 << (FLASH_LOG2 - 3)));
    localparam logic [AW-1:0] FL_HI = AW'(33'h2000_0000);

    route_cfg_t    cfg;
    logic [NT-1:0] dec_tgt;
    logic [AW-1:0] dec_addr;
    route_rsp_t    rsp_d, rsp_q;

    addr_route_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    addr_route_match #(
        .GFX_BASE   (GFX_BASE),
        .GFX_SIZE   (GFX_SIZE),
        .FLASH_LOG2 (FLASH_LOG2)
    ) u_match (
        .addr  (req_addr),
        .cfg   (cfg),
        .tgt   (dec_tgt),
        .xaddr (dec_addr)
    );

    assign req_ready = !rsp_q.valid || rsp_ready;

    always_comb begin
        rsp_d = rsp_q;
        if (rsp_ready) rsp_d.valid = 1'b0;
        if (req_valid && req_ready) begin
            rsp_d.valid = 1'b1;
            rsp_d.tgt   = dec_tgt;
            rsp_d.addr  = dec_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_tgt   = rsp_q.tgt;
    assign rsp_addr  = rsp_q.addr;

    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot(rsp_tgt));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_tgt) && $stable(rsp_addr));
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid);
    p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready && !req_valid |=> !rsp_valid);
    p_flash_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_addr >= FL_LO && req_addr < FL_HI
        |=> rsp_tgt[T_FLASH]);
    p_legacy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_addr >= 33'h1_4000 && req_addr < 33'h2_0000
        |=> rsp_tgt[T_LEGACY]);
endmodule

// File: tb/addr_route_dec_test.sv
module addr_route_dec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [9:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [32:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [5:0]  rsp_tgt;
    logic [32:0] rsp_addr;

    int n_chk = 0;
    int n_err = 0;
    logic done = 1'b0;

    longint unsigned m_low = 48, m_top = 64, m_rb = 64, m_rl = 79, m_en = 0;
    localparam longint unsigned G64 = 64'h400_0000;

    localparam logic [5:0] E_DRAM = 6'b000001, E_LEG = 6'b000010, E_MMIO = 6'b000100,
                           E_GFX = 6'b001000, E_FLASH = 6'b010000, E_ERR = 6'b100000;

    always #10 clk = ~clk;   // 50 MHz

    addr_route_dec uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_tgt(rsp_tgt), .rsp_addr(rsp_addr)
    );

    function automatic logic [32:0] u(input longint unsigned b);
        return 33'(b >> 3);
    endfunction

    function automatic void model(input logic [32:0] a, output logic [5:0] t,
                                  output logic [32:0] o);
        longint unsigned b = {28'd0, a, 3'b000};
        o = a;
        if (b >= 64'hFF00_0000 && b < 64'h1_0000_0000)      t = E_FLASH;
        else if (b >= 64'hE000_0000 && b < 64'hF000_0000)   t = E_GFX;
        else if (b >= m_low * G64 && b < 64'h1_0000_0000)   t = E_MMIO;
        else if (b >= 64'hA_0000 && b < 64'h10_0000)        t = E_LEG;
        else if (m_en != 0 && m_rb <= m_rl && b >= m_rb * G64 && b < (m_rl + 1) * G64) begin
            t = E_DRAM;
            o = u(b - m_rb * G64 + m_low * G64);
        end
        else if (b < m_top * G64)                           t = E_DRAM;
        else                                                t = E_ERR;
    endfunction

    task automatic cmp(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] i, input logic [9:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = i; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        case (i)
            3'd0: m_low = v;
            3'd1: m_rb  = v;
            3'd2: m_rl  = v;
            3'd3: m_top = v;
            default: m_en = v[0];
        endcase
    endtask

    task automatic send(input string tag, input logic [32:0] a,
                        input logic [5:0] et, input logic [32:0] ea);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cmp(tag, {rsp_valid, rsp_tgt, rsp_addr}, {1'b1, et, ea});
    endtask

    task automatic send_m(input string tag, input logic [32:0] a);
        logic [5:0] et;
        logic [32:0] ea;
        model(a, et, ea);
        send(tag, a, et, ea);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 reset", {38'd0, req_ready, rsp_valid}, {38'd0, 1'b1, 1'b0});

        send("R8 legacy low",  u(64'hA_0000),     E_LEG,  u(64'hA_0000));
        send("R8 legacy high", u(64'hF_FFF8),     E_LEG,  u(64'hF_FFF8));
        send("R11 below legacy", u(64'h9_FFF8),   E_DRAM, u(64'h9_FFF8));
        send("R11 dram 1MB",   u(64'h10_0000),    E_DRAM, u(64'h10_0000));
        send("R11 dram top",   u(64'hBFFF_FFF8),  E_DRAM, u(64'hBFFF_FFF8));
        send("R7 mmio low",    u(64'hC000_0000),  E_MMIO, u(64'hC000_0000));
        send("R7 mmio after gfx", u(64'hF000_0000), E_MMIO, u(64'hF000_0000));
        send("R6 gfx low",     u(64'hE000_0000),  E_GFX,  u(64'hE000_0000));
        send("R6 gfx high",    u(64'hEFFF_FFF8),  E_GFX,  u(64'hEFFF_FFF8));
        send("R5 flash low",   u(64'hFF00_0000),  E_FLASH, u(64'hFF00_0000));
        send("R5 flash high",  u(64'hFFFF_FFF8),  E_FLASH, u(64'hFFFF_FFF8));
        send("R12 above top",  u(64'h1_0000_0000), E_ERR, u(64'h1_0000_0000));
        send("R10 reclaim off", u(64'h1_2000_0000), E_ERR, u(64'h1_2000_0000));

        cfg_wr(3'd4, 10'd1);
        send("R9 reclaim base", u(64'h1_0000_0000), E_DRAM, u(64'hC000_0000));
        send("R9 reclaim end",  u(64'h1_3FFF_FFF8), E_DRAM, u(64'hFFFF_FFF8));
        send("R12 past reclaim", u(64'h1_4000_0000), E_ERR, u(64'h1_4000_0000));
        cfg_wr(3'd1, 10'd80);
        send("R10 base over limit", u(64'h1_4000_0000), E_ERR, u(64'h1_4000_0000));
        cfg_wr(3'd1, 10'd64);

        cfg_wr(3'd0, 10'd40);
        send("R13 new low top", u(64'hA000_0000), E_MMIO, u(64'hA000_0000));
        send("R9 R13 reclaim moved", u(64'h1_0000_0000), E_DRAM, u(64'hA000_0000));
        cfg_wr(3'd3, 10'd96);
        send("R11 R13 dram above 4G", u(64'h1_4000_0000), E_DRAM, u(64'h1_4000_0000));
        send("R12 R13 new top",  u(64'h1_8000_0000), E_ERR, u(64'h1_8000_0000));
        cfg_wr(3'd0, 10'd63);
        send("R5 flash over low top", u(64'hFF80_0000), E_FLASH, u(64'hFF80_0000));

        // stall: result must hold while the consumer refuses it
        @(negedge clk);
        req_valid = 1'b1; req_addr = u(64'hE000_0008); rsp_ready = 1'b0;
        @(negedge clk);
        cmp("R2 stall accept", {33'd0, rsp_valid, rsp_tgt}, {33'd0, 1'b1, E_GFX});
        req_addr = u(64'hA_0008);
        repeat (3) begin
            @(negedge clk);
            cmp("R3 hold", {rsp_valid, rsp_tgt, rsp_addr}, {1'b1, E_GFX, u(64'hE000_0008)});
            cmp("R3 not ready", {39'd0, req_ready}, 40'd0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cmp("R2 after release", {rsp_valid, rsp_tgt, rsp_addr}, {1'b1, E_LEG, u(64'hA_0008)});
        @(negedge clk);
        cmp("R2 drained", {38'd0, rsp_valid, req_ready}, {38'd0, 1'b0, 1'b1});

        for (int it = 0; it < 600; it++) begin
            longint unsigned b;
            if (it % 50 == 0) begin
                cfg_wr(3'd0, 10'(32 + $urandom % 28));
                cfg_wr(3'd3, 10'(40 + $urandom % 60));
                cfg_wr(3'd1, 10'(60 + $urandom % 30));
                cfg_wr(3'd2, 10'(60 + $urandom % 30));
                cfg_wr(3'd4, 10'($urandom % 2));
            end
            case ($urandom % 8)
                0: b = 64'hFF00_0000 + $urandom % 32'h100_0000;
                1: b = 64'hDF00_0000 + $urandom % 32'h1200_0000;
                2: b = 64'h8000_0000 + $urandom % 32'h8000_0000;
                3: b = 64'h9_0000 + $urandom % 32'h8_0000;
                4: b = m_rb * G64 - 64'h100_0000 + $urandom % (32'h100_0000 + 32'(m_rl - m_rb + 2) * 32'h400_0000);
                5: b = 64'h1_0000_0000 + {32'd0, $urandom} + {32'd0, $urandom % 2, 31'd0};
                6: b = {32'd0, 1'b0, $urandom % 32'h8000_0000};
                default: b = {28'd0, $urandom % 16, $urandom};
            endcase
            send_m("R4 R9 R11 random", u(b));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule